// File: doc/BRIEF.md
# SONET A1 Byte Word Aligner Deserializer

This block turns a serial bit stream, clocked at the line bit rate, into bytes on an eight-bit parallel bus. It keeps a rolling window of the last eight received bits and a free-running divide-by-8 phase counter. Each time the counter wraps, it loads the window onto the bus and pulses a one-cycle byte strobe. The strobe rate is one eighth of the bit rate.

The byte boundary can be moved by a hunt. The hunt is armed by a falling edge on an active-low out-of-frame input while a disable input is low. While it runs, the window is compared against the SONET A1 framing byte on every bit clock. The bus is held, the strobe is silent and the valid flag is low. At the first match, the counter is reset so that the A1 byte lands whole on the bus, with its first-received bit in the D1 position (bit 7). The valid flag then rises and the phase stays fixed until a new hunt is armed.

A frame-found pulse from the downstream A2 boundary detector ends a hunt. So does a falling out-of-frame edge while the disable input is high. The out-of-frame input is sampled through a short register pipe in the bit-clock domain, and its edges are found there.

Top module: `sonet_word_aligner`

## Requirements
- R1: While reset is asserted, par_out is 0 and byte_strobe, data_valid and hunting are all 0.
- R2: oof_n is seen low at one clock edge after being seen high, with hunt_dis low. At the following edge (the second edge that samples oof_n low), hunting goes to 1 and data_valid goes to 0.
- R3: From the edge after hunting rises until the hunt locks or stops, byte_strobe stays 0 and par_out keeps its value.
- R4: While hunting, at the edge that samples the last bit of A1 = 8'hF6 (bit 7 is sent first on the line), par_out becomes 8'hF6 with the first-received bit in par_out[7] (D1) and the last in par_out[0] (D8). At the same edge byte_strobe is 1, data_valid is 1 and hunting is 0.
- R5: After a lock, byte_strobe is a one-cycle pulse on every 8th edge. At each pulse, par_out holds the 8 most recent bits, the earliest in bit 7.
- R6: Once locked, an A1 pattern arriving at any other bit offset does not move the strobe phase, and data_valid stays 1.
- R7: frame_pulse high at an edge during a hunt ends the hunt at that edge. A later A1 does not set data_valid. The phase counter keeps running through the hunt, so the strobe cadence continues from before the hunt.
- R8: A falling edge on oof_n with hunt_dis high ends a running hunt with the same two-edge latency as R2. It never starts a hunt, and the strobe keeps its cadence.
- R9: A falling edge on oof_n with hunt_dis low re-arms the hunt even when the block is already locked. The new lock may land at any of the 8 bit offsets of the old phase.
- R10: When an arming edge and frame_pulse reach the control logic at the same clock edge, arming wins and hunting goes to 1.
- R11: Arming is edge sensitive. oof_n held low after a hunt has been stopped does not start a new hunt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit, sampled on each rising clock edge |
| oof_n | input | 1 | Active-low out-of-frame indication; its falling edge arms or stops the hunt |
| hunt_dis | input | 1 | When high, a falling oof_n edge stops the hunt instead of arming it |
| frame_pulse | input | 1 | Frame-found pulse that ends a hunt |
| par_out | output | 8 | Parallel byte; bit 7 is D1, the first-received bit |
| byte_strobe | output | 1 | One-cycle pulse when par_out carries a new byte |
| data_valid | output | 1 | High once the byte boundary has locked to A1; low from hunt arming until the next lock |
| hunting | output | 1 | High while the A1 search is running |

## Verification
The bench builds the block with its defaults: an 8-bit word, A1 = 8'hF6 as the search pattern, and a two-register sampling pipe on the out-of-frame input. These defaults make the arming latency exactly two edges, and the bench counts on that. A vector table puts the A1 byte after leading junk of zero to seven bits. This lands a lock at every one of the eight offsets of the previous phase, and the byte that follows each lock checks the new cadence. Directed cases then cover the fixed phase after lock, each of the two ways a hunt can stop, arming and stopping in the same cycle, and a level-held oof_n.

// File: rtl/sonet_align_pkg.sv
package sonet_align_pkg;

  // Hunt controller states.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,  // not hunting, phase free-running
    ST_SEARCH  = 2'b01,  // comparing every bit window with the pattern
    ST_ALIGNED = 2'b10   // locked by a match, waiting for a frame pulse
  } hunt_state_e;

  // SONET A1 framing byte, first line bit in the MSB.
  localparam logic [7:0] A1_BYTE = 8'hF6;

endpackage

// File: rtl/sonet_align_shift.sv
module sonet_align_shift #(
  parameter int unsigned         WORD_W  = 8,
  parameter logic [WORD_W-1:0]   PATTERN = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  output logic [WORD_W-1:0] word_o,
  output logic              match_o
);

  localparam int unsigned HIST_W = WORD_W - 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // Window of the newest WORD_W bits: the oldest in the MSB.
  always_comb begin
    word_o  = {hist_q, ser_i};
    match_o = (word_o == PATTERN);
    hist_d  = word_o[HIST_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // R5: each window continues the one before it by one bit.
  p_window_shift_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0]));

endmodule

// File: rtl/sonet_hunt_ctrl.sv
module sonet_hunt_ctrl
  import sonet_align_pkg::*;
#(
  parameter int unsigned EDGE_PIPE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oof_n_i,
  input  logic dis_i,
  input  logic frame_i,
  input  logic match_i,
  output logic search_o,
  output logic realign_o,
  output logic valid_o
);

  localparam int unsigned LAST = EDGE_PIPE - 1;

  logic [EDGE_PIPE-1:0] pipe_q;
  hunt_state_e          state_q, state_d;
  logic                 valid_q, valid_d;
  logic                 fall;
  logic                 arm;
  logic                 stop;

  // Sampling pipe for the out-of-frame input, reset to the idle (high) level.
  generate
    for (genvar k = 0; k < EDGE_PIPE; k++) begin : g_pipe
      if (k == 0) begin : g_head
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[0] <= 1'b1;
          else         pipe_q[0] <= oof_n_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[k] <= 1'b1;
          else         pipe_q[k] <= pipe_q[k-1];
        end
      end
    end
  endgenerate

  always_comb begin
    fall  = pipe_q[LAST] & ~pipe_q[LAST-1];
    arm   = fall & ~dis_i;
    stop  = (fall & dis_i) | frame_i;

    state_d   = state_q;
    valid_d   = valid_q;
    realign_o = 1'b0;

    if (arm) begin
      state_d = ST_SEARCH;
      valid_d = 1'b0;
    end else if (stop) begin
      state_d = ST_IDLE;
    end else if ((state_q == ST_SEARCH) && match_i) begin
      state_d   = ST_ALIGNED;
      valid_d   = 1'b1;
      realign_o = 1'b1;
    end

    search_o = (state_q == ST_SEARCH);
    valid_o  = valid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  // R2: an enabled falling edge starts the search and clears validity.
  p_arm_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !dis_i) |=> (search_o && !valid_o));

  // R8: a disabled falling edge never leaves the block searching.
  p_dis_stop_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && dis_i) |=> !search_o);

  // R7 / R10: a frame pulse stops the search unless arming coincides.
  p_frame_stop_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !(fall && !dis_i)) |=> !search_o);

  // R4: validity only rises out of a search that saw the pattern.
  p_valid_src_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(search_o && match_i));

  // R1: no encoding outside the three states.
  p_state_legal_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11);

endmodule

// File: rtl/sonet_phase_ctr.sv
module sonet_phase_ctr #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              realign_i,
  input  logic              search_i,
  output logic [WORD_W-1:0] par_o,
  output logic              strobe_o
);

  localparam int unsigned          CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]     CNT_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] par_q, par_d;
  logic              strobe_q, strobe_d;
  logic              wrap;
  logic              load_en;

  always_comb begin
    wrap    = (cnt_q == CNT_LAST);
    load_en = realign_i | (wrap & ~search_i);

    if (realign_i)  cnt_d = '0;
    else if (wrap)  cnt_d = '0;
    else            cnt_d = cnt_q + CNT_W'(1);

    strobe_d = load_en;
    par_d    = load_en ? word_i : par_q;

    par_o    = par_q;
    strobe_o = strobe_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      par_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      strobe_q <= strobe_d;
      if (load_en) begin
        par_q <= par_d;
      end
    end
  end

  // R4: a realignment puts the matching window on the bus with a strobe.
  p_lock_load_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> (strobe_o && (par_o == $past(word_i))));

  // R3: a search without a match keeps the bus quiet and still.
  p_quiet_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (search_i && !realign_i) |=> (!strobe_o && $stable(par_o)));

  // R5: the strobe is a single-cycle pulse.
  p_pulse_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/sonet_word_aligner.sv
module sonet_word_aligner
  import sonet_align_pkg::*;
#(
  parameter int unsigned       WORD_W    = 8,
  parameter logic [WORD_W-1:0] SYNC_WORD = A1_BYTE,
  parameter int unsigned       EDGE_PIPE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              oof_n,
  input  logic              hunt_dis,
  input  logic              frame_pulse,
  output logic [WORD_W-1:0] par_out,
  output logic              byte_strobe,
  output logic              data_valid,
  output logic              hunting
);

  logic [WORD_W-1:0] window;
  logic              match;
  logic              realign;
  logic              search;

  sonet_align_shift #(
    .WORD_W  (WORD_W),
    .PATTERN (SYNC_WORD)
  ) u_shift (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ser_i   (ser_in),
    .word_o  (window),
    .match_o (match)
  );

  sonet_hunt_ctrl #(
    .EDGE_PIPE (EDGE_PIPE)
  ) u_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .oof_n_i   (oof_n),
    .dis_i     (hunt_dis),
    .frame_i   (frame_pulse),
    .match_i   (match),
    .search_o  (search),
    .realign_o (realign),
    .valid_o   (data_valid)
  );

  sonet_phase_ctr #(
    .WORD_W (WORD_W)
  ) u_phase (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .word_i    (window),
    .realign_i (realign),
    .search_i  (search),
    .par_o     (par_out),
    .strobe_o  (byte_strobe)
  );

  assign hunting = search;

  // R4: a lock leaves the search and raises validity together.
  p_lock_exit_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hunting) && data_valid |-> byte_strobe);

  // R6: validity never drops except through arming.
  p_valid_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> hunting);

endmodule

// File: tb/test_sonet_word_aligner.sv
`timescale 1ns/1ps
module test_sonet_word_aligner;

  localparam int unsigned WORD_W = 8;
  localparam logic [7:0]  A1 = 8'hF6;
  localparam int unsigned NVEC = 8;

  // Vector: [19:16] lead length, [15:8] lead bits (LSBs, sent MSB first),
  // [7:0] byte sent after A1 and expected at the next strobe.
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    20'h0_00_28, 20'h1_01_28, 20'h2_02_5A, 20'h3_07_28,
    20'h4_0B_C3, 20'h5_1D_28, 20'h6_3D_81, 20'h7_7B_F6
  };

  logic             clk;
  logic             rst_n;
  logic             ser_in;
  logic             oof_n;
  logic             hunt_dis;
  logic             frame_pulse;
  logic [WORD_W-1:0] par_out;
  logic             byte_strobe;
  logic             data_valid;
  logic             hunting;

  int unsigned n_run;
  int unsigned n_fail;
  bit          done;
  logic [7:0]  hist;
  int unsigned ph;
  logic [7:0]  held;

  sonet_word_aligner i_sonet_word_aligner (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .oof_n       (oof_n),
    .hunt_dis    (hunt_dis),
    .frame_pulse (frame_pulse),
    .par_out     (par_out),
    .byte_strobe (byte_strobe),
    .data_valid  (data_valid),
    .hunting     (hunting)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bit, let the edge sample it, return 1 ns after the edge.
  task automatic tick(input logic b);
    ser_in = b;
    @(posedge clk);
    #1;
    hist = {hist[6:0], b};
    ph   = (ph == 7) ? 0 : ph + 1;
  endtask

  // Arm a hunt, then pad with zeros while checking the quiet bus.
  task automatic arm_and_pad();
    oof_n = 1'b0;
    tick(1'b0);
    tick(1'b0);
    chk(hunting == 1'b1, "R2 hunting after arm", 32'(hunting), 1);
    chk(data_valid == 1'b0, "R2 valid cleared", 32'(data_valid), 0);
    oof_n = 1'b1;
    held  = par_out;
    for (int i = 0; i < 6; i++) begin
      tick(1'b0);
      chk(byte_strobe == 1'b0, "R3 no strobe while hunting", 32'(byte_strobe), 0);
    end
    chk(par_out == held, "R3 par_out held", 32'(par_out), 32'(held));
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    hist = '0; ph = 0; held = '0;
    rst_n = 1'b0; ser_in = 1'b0; oof_n = 1'b1; hunt_dis = 1'b0; frame_pulse = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(par_out == 8'h00, "R1 par_out reset", 32'(par_out), 0);
    chk(byte_strobe == 1'b0, "R1 strobe reset", 32'(byte_strobe), 0);
    chk(data_valid == 1'b0, "R1 valid reset", 32'(data_valid), 0);
    chk(hunting == 1'b0, "R1 hunting reset", 32'(hunting), 0);
    rst_n = 1'b1;
    tick(1'b0);
    tick(1'b0);

    // Table walk: lock at each of the eight offsets (R4, R5, R9).
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] len;
      logic [7:0] lead;
      logic [7:0] follow;
      len    = VEC[v][19:16];
      lead   = VEC[v][15:8];
      follow = VEC[v][7:0];
      arm_and_pad();
      for (int i = int'(len) - 1; i >= 0; i--) begin
        tick(lead[i]);
        chk(byte_strobe == 1'b0, "R3 no strobe in lead", 32'(byte_strobe), 0);
      end
      for (int i = 7; i >= 0; i--) begin
        tick(A1[i]);
        if (i != 0) begin
          chk(byte_strobe == 1'b0, "R3 no strobe before match", 32'(byte_strobe), 0);
          chk(par_out == held, "R3 par_out held to match", 32'(par_out), 32'(held));
        end
      end
      chk(par_out == A1, "R4 A1 on bus, D1 in bit 7", 32'(par_out), 32'(A1));
      chk(byte_strobe == 1'b1, "R4 strobe at lock", 32'(byte_strobe), 1);
      chk(data_valid == 1'b1, "R4 valid at lock", 32'(data_valid), 1);
      chk(hunting == 1'b0, "R4 hunting off at lock", 32'(hunting), 0);
      ph = 0;
      for (int i = 7; i >= 0; i--) begin
        tick(follow[i]);
        chk(byte_strobe == (i == 0), "R9 R5 strobe cadence after relock",
            32'(byte_strobe), 32'(i == 0));
      end
      chk(par_out == follow, "R5 next byte", 32'(par_out), 32'(follow));
    end

    // R6: a misaligned A1 after lock does not move the phase.
    begin
      logic [23:0] stream;
      stream = {3'b000, A1, 13'h0A5};
      for (int i = 23; i >= 0; i--) begin
        tick(stream[i]);
        chk(byte_strobe == (ph == 0), "R6 phase held after lock",
            32'(byte_strobe), 32'(ph == 0));
        if (ph == 0)
          chk(par_out == hist, "R5 window at strobe", 32'(par_out), 32'(hist));
      end
      chk(data_valid == 1'b1, "R6 valid kept", 32'(data_valid), 1);
    end

    // R7: frame pulse ends a hunt; a later A1 does not lock.
    arm_and_pad();
    frame_pulse = 1'b1;
    tick(1'b0);
    frame_pulse = 1'b0;
    chk(hunting == 1'b0, "R7 hunting stopped by frame pulse", 32'(hunting), 0);
    begin
      logic [15:0] stream;
      stream = {2'b01, A1, 6'b001100};
      for (int i = 15; i >= 0; i--) begin
        tick(stream[i]);
        chk(byte_strobe == (ph == 0), "R7 cadence kept after stop",
            32'(byte_strobe), 32'(ph == 0));
      end
    end
    chk(data_valid == 1'b0, "R7 no lock after stop", 32'(data_valid), 0);

    // R8: disabled falling edge from idle does not arm.
    hunt_dis = 1'b1;
    oof_n    = 1'b0;
    tick(1'b0);
    tick(1'b0);
    chk(hunting == 1'b0, "R8 no arm when disabled", 32'(hunting), 0);
    for (int i = 0; i < 8; i++) begin
      tick(1'b1);
      chk(byte_strobe == (ph == 0), "R8 cadence while disabled",
          32'(byte_strobe), 32'(ph == 0));
    end
    oof_n = 1'b1; hunt_dis = 1'b0;
    tick(1'b0);
    tick(1'b0);

    // R8: disabled falling edge stops a running hunt.
    arm_and_pad();
    hunt_dis = 1'b1;
    oof_n    = 1'b0;
    tick(1'b0);
    chk(hunting == 1'b1, "R8 still hunting one edge in", 32'(hunting), 1);
    tick(1'b0);
    chk(hunting == 1'b0, "R8 hunt stopped by disabled edge", 32'(hunting), 0);
    oof_n = 1'b1; hunt_dis = 1'b0;
    tick(1'b0);
    tick(1'b0);

    // R10: arming and frame pulse at the same edge.
    oof_n = 1'b0;
    tick(1'b0);
    frame_pulse = 1'b1;
    tick(1'b0);
    frame_pulse = 1'b0;
    chk(hunting == 1'b1, "R10 arming wins over frame pulse", 32'(hunting), 1);

    // R11: oof_n held low does not re-arm after a stop.
    frame_pulse = 1'b1;
    tick(1'b0);
    frame_pulse = 1'b0;
    chk(hunting == 1'b0, "R7 frame pulse stops hunt", 32'(hunting), 0);
    for (int i = 0; i < 10; i++) begin
      tick(1'b0);
      chk(hunting == 1'b0, "R11 level-low oof_n does not arm", 32'(hunting), 0);
    end
    oof_n = 1'b1;
    tick(1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule